// File: doc/BRIEF.md
# Sensorless Spindle Commutation Controller

This block chooses the three-bit commutation state that drives a three-phase spindle motor without position sensors. Software sets it up through a small register interface: a control word at address 1 and a delay limit at address 6. An external comparator reports the motor's back-EMF zero crossings as single-cycle pulses that are already synchronous to the clock. In automatic mode the block measures the time between crossings. After each crossing it waits half of the interval just measured and then advances the motor to the next state.

Software can also take over in several ways. In manual mode it writes the state directly. It can stop the motor with the run bit. It can park the drive in a fixed sleep code. It can shift the sequence by half a turn of the electrical cycle to apply a reverse brake. If crossings stop arriving, an interval limit forces the next step. A prescaler selects the time base of the counters.

Top module: `spinCommCtrl`

## Requirements
- R1: While `porOk` is low, `commCode` is 3'b101. This also holds whenever control bit 6 (awake) is 0. Reset clears the control word, so after `porOk` rises the output stays 3'b101 until software sets bit 6.
- R2: A write with `addr`=1 loads the control word. A write with `addr`=6 loads the limit: bits 10..0 are the limit and bit 11 is the low divider select. Writes to any other address have no effect. A read with `addr`=1 returns `commCode` in bits 2..0 in the same cycle. Any other read returns 0.
- R3: With the awake bit set and the run bit (bit 3) at 0, the state index does not advance. Zero crossings and the limit have no effect in this condition.
- R4: With run=1 and manual (bit 4)=1, `commCode` equals control bits 2..0 from the write edge onward. Crossings do not advance the sequence. With manual=1 and run=0, the output shows the held sequence code.
- R5: The sequence codes by index 0..5 are 001, 011, 010, 110, 100, 000. The index is 0 after reset, advances by one per step and wraps from 5 to 0.
- R6: Automatic mode means run=1, manual=0 and awake=1. A crossing is sampled at edge k. Its interval T is the number of ticks since the previous crossing, or since the edge on which automatic mode took effect, and saturates at the limit. The step then lands on edge k + f·floor(T/2) + 1, where f is the divider factor.
- R7: A crossing that arrives while a step is pending cancels that step and starts a new measurement and delay. A crossing on the edge a step would fire suppresses that step.
- R8: In automatic mode with no pending step, a step is forced once the interval reaches the limit L. The measurement then restarts, so forced steps repeat every f·(L−1)+1 cycles.
- R9: The divider factor f is 1, 2, 4 or 8, selected by {control bit 5, limit bit 11} read as a two-bit number (0 to 3).
- R10: With control bit 11 (reverse brake) set, the output is the code three positions ahead of the current index, and steps continue. Clearing the bit restores the unshifted code on the write edge.
- R11: Clearing the awake bit parks the output at 3'b101 and holds the index. Setting it again restores the code of the held index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porOk | input | 1 | Power-on reset, active low, asynchronous |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wrData | input | 12 | Write data |
| zcPulse | input | 1 | Single-cycle zero-crossing pulse |
| commCode | output | 3 | Commutation code to the spindle driver |
| rdData | output | 12 | Read data, combinational |

## Verification
Register writes change `commCode` on the edge that samples the strobe. This covers manual states, brake shifts and parking. An automatic step lands f·floor(T/2)+1 edges after the crossing edge, and a forced step lands f·(L−1)+1 edges after the last restart. The bench drives every stimulus at a negative edge, so it knows the exact edge that samples it. It queues each expected code with that edge number. A monitor at each negative edge pops an item whenever the code changes and compares both the value and the edge count. Any change with an empty queue is reported as an unexpected step, which covers the cases where the rules say nothing may happen.

// File: rtl/spinCommPkg.sv
package spinCommPkg;

  localparam int NUM_PHASES = 6;
  localparam logic [2:0] PARK_CODE = 3'b101;

  typedef struct packed {
    logic       brake;
    logic       awake;
    logic       divHi;
    logic       manual;
    logic       run;
    logic [2:0] manState;
  } modeT;

  // control -> datapath strobes
  typedef struct packed {
    logic restart;
    logic latch;
  } dpCmdT;

  // datapath -> control status
  typedef struct packed {
    logic dlyZero;
    logic atLimit;
  } dpStatT;

  function automatic logic [2:0] phaseCode(input logic [2:0] idx);
    logic [2:0] code;
    case (idx)
      3'd0:    code = 3'b001;
      3'd1:    code = 3'b011;
      3'd2:    code = 3'b010;
      3'd3:    code = 3'b110;
      3'd4:    code = 3'b100;
      3'd5:    code = 3'b000;
      default: code = PARK_CODE;
    endcase
    return code;
  endfunction

  function automatic logic [2:0] phaseAdvance(input logic [2:0] idx, input logic [2:0] by);
    logic [3:0] sum;
    sum = {1'b0, idx} + {1'b0, by};
    if (sum >= 4'(NUM_PHASES)) sum = sum - 4'(NUM_PHASES);
    return sum[2:0];
  endfunction

endpackage

// File: rtl/spinCommRegs.sv
module spinCommRegs
  import spinCommPkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 3,
  parameter int CNT_W     = 11,
  parameter int CTRL_ADDR = 1,
  parameter int LIM_ADDR  = 6,
  parameter int LIM_RESET = 2047
) (
  input  logic              clk,
  input  logic              porOk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output modeT              mode,
  output logic [CNT_W-1:0]  limit,
  output logic              divLo
);

  localparam int BIT_RUN   = 3;
  localparam int BIT_MAN   = 4;
  localparam int BIT_DIV   = 5;
  localparam int BIT_AWAKE = 6;
  localparam int BIT_BRAKE = DATA_W - 1;
  localparam int BIT_DLO   = CNT_W;

  logic ctrlHit;
  logic limHit;

  assign ctrlHit = wrEn && (addr == ADDR_W'(CTRL_ADDR));
  assign limHit  = wrEn && (addr == ADDR_W'(LIM_ADDR));

  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk) begin
      mode  <= '0;
      limit <= CNT_W'(LIM_RESET);
      divLo <= 1'b0;
    end else begin
      if (ctrlHit) begin
        mode.manState <= wrData[2:0];
        mode.run      <= wrData[BIT_RUN];
        mode.manual   <= wrData[BIT_MAN];
        mode.divHi    <= wrData[BIT_DIV];
        mode.awake    <= wrData[BIT_AWAKE];
        mode.brake    <= wrData[BIT_BRAKE];
      end
      if (limHit) begin
        limit <= wrData[CNT_W-1:0];
        divLo <= wrData[BIT_DLO];
      end
    end
  end

endmodule

// File: rtl/spinCommCount.sv
module spinCommCount
  import spinCommPkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int DIV_STEP = 1
) (
  input  logic             clk,
  input  logic             porOk,
  input  dpCmdT            cmd,
  input  logic [CNT_W-1:0] limit,
  input  logic [1:0]       divSel,
  output dpStatT           stat
);

  localparam int PRE_W = 3 * DIV_STEP;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             tick;
  logic [CNT_W-1:0] intCnt;
  logic [CNT_W-1:0] dlyCnt;

  always_comb begin
    for (int b = 0; b < PRE_W; b++) begin
      preMask[b] = (b < int'(divSel) * DIV_STEP);
    end
  end

  assign tick = &(preCnt | ~preMask);

  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk) begin
      preCnt <= '0;
      intCnt <= CNT_W'(1);
      dlyCnt <= '0;
    end else begin
      if (cmd.restart) begin
        preCnt <= '0;
        intCnt <= CNT_W'(1);
      end else begin
        preCnt <= preCnt + 1'b1;
        if (tick && (intCnt < limit)) intCnt <= intCnt + 1'b1;
      end
      if (cmd.latch) dlyCnt <= intCnt >> 1;
      else if (tick && (dlyCnt != '0)) dlyCnt <= dlyCnt - 1'b1;
    end
  end

  assign stat.dlyZero = (dlyCnt == '0);
  assign stat.atLimit = (intCnt >= limit);

  // interval only moves upward between restarts
  assert_count_monotone_R6: assert property (@(posedge clk) disable iff (!porOk)
    !cmd.restart |=> intCnt >= $past(intCnt));

  // pending delay never grows unless a new crossing reloads it
  assert_delay_falls_R7: assert property (@(posedge clk) disable iff (!porOk)
    !cmd.latch |=> dlyCnt <= $past(dlyCnt));

endmodule

// File: rtl/spinCommSeq.sv
module spinCommSeq
  import spinCommPkg::*;
(
  input  logic       clk,
  input  logic       porOk,
  input  modeT       mode,
  input  logic       zcPulse,
  input  dpStatT     stat,
  output dpCmdT      cmd,
  output logic [2:0] commCode
);

  typedef enum logic [1:0] {ST_IDLE, ST_MEAS, ST_PEND} seqStateT;

  seqStateT   state;
  seqStateT   nextState;
  logic       active;
  logic       step;
  logic [2:0] idx;
  logic [2:0] shownIdx;

  assign active = mode.run && !mode.manual && mode.awake;

  always_comb begin
    cmd       = '0;
    step      = 1'b0;
    nextState = state;
    if (!active) begin
      cmd.restart = 1'b1;
      nextState   = ST_IDLE;
    end else if (zcPulse) begin
      cmd.restart = 1'b1;
      cmd.latch   = 1'b1;
      nextState   = ST_PEND;
    end else if (state == ST_PEND) begin
      if (stat.dlyZero) begin
        step      = 1'b1;
        nextState = ST_MEAS;
      end
    end else begin
      nextState = ST_MEAS;
      if (stat.atLimit) begin
        step        = 1'b1;
        cmd.restart = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= nextState;
      if (step) idx <= phaseAdvance(idx, 3'd1);
    end
  end

  assign shownIdx = mode.brake ? phaseAdvance(idx, 3'd3) : idx;

  always_comb begin
    if (!mode.awake)                 commCode = PARK_CODE;
    else if (mode.run && mode.manual) commCode = mode.manState;
    else                             commCode = phaseCode(shownIdx);
  end

  assert_phase_legal_R5: assert property (@(posedge clk) disable iff (!porOk)
    idx < 3'(NUM_PHASES));

  assert_phase_order_R5: assert property (@(posedge clk) disable iff (!porOk)
    (idx != $past(idx)) |-> (idx == phaseAdvance($past(idx), 3'd1)));

  assert_hold_inactive_R3: assert property (@(posedge clk) disable iff (!porOk)
    !active |=> $stable(idx));

  assert_zc_defers_R7: assert property (@(posedge clk) disable iff (!porOk)
    (active && zcPulse) |=> $stable(idx));

endmodule

// File: rtl/spinCommCtrl.sv
module spinCommCtrl
  import spinCommPkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 3,
  parameter int CNT_W     = 11,
  parameter int DIV_STEP  = 1,
  parameter int CTRL_ADDR = 1,
  parameter int LIM_ADDR  = 6,
  parameter int LIM_RESET = 2047
) (
  input  logic              clk,
  input  logic              porOk,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              zcPulse,
  output logic [2:0]        commCode,
  output logic [DATA_W-1:0] rdData
);

  modeT             mode;
  logic [CNT_W-1:0] limit;
  logic             divLo;
  dpCmdT            cmd;
  dpStatT           stat;

  spinCommRegs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .CTRL_ADDR(CTRL_ADDR), .LIM_ADDR(LIM_ADDR), .LIM_RESET(LIM_RESET)
  ) u_regs (
    .clk(clk), .porOk(porOk), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .mode(mode), .limit(limit), .divLo(divLo)
  );

  spinCommCount #(.CNT_W(CNT_W), .DIV_STEP(DIV_STEP)) u_count (
    .clk(clk), .porOk(porOk), .cmd(cmd), .limit(limit),
    .divSel({mode.divHi, divLo}), .stat(stat)
  );

  spinCommSeq u_seq (
    .clk(clk), .porOk(porOk), .mode(mode), .zcPulse(zcPulse),
    .stat(stat), .cmd(cmd), .commCode(commCode)
  );

  always_comb begin
    rdData = '0;
    if (rdEn && (addr == ADDR_W'(CTRL_ADDR))) rdData[2:0] = commCode;
  end

endmodule

// File: tb/spinCommCtrl_tb.sv
module spinCommCtrl_tb;

  logic        clk = 1'b0;
  logic        porOk = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [11:0] wrData = '0;
  logic        zcPulse = 1'b0;
  logic [2:0]  commCode;
  logic [11:0] rdData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [2:0] code;
    int         edgeNo;
    string      tag;
  } expT;

  expT        sb[$];
  logic [2:0] lastPushed = 3'b101;
  logic [2:0] prevSeen = 3'b101;

  spinCommCtrl u_dut (
    .clk(clk), .porOk(porOk), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .zcPulse(zcPulse), .commCode(commCode), .rdData(rdData)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic pushExp(input logic [2:0] code, input int edgeNo, input string tag);
    if (code != lastPushed) begin
      expT it;
      it.code = code; it.edgeNo = edgeNo; it.tag = tag;
      sb.push_back(it);
      lastPushed = code;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: every code change must match the queue head
  always @(negedge clk) begin
    if (commCode !== prevSeen) begin
      if (sb.size() == 0) begin
        chk(1'b0, "unexpected code change", int'(commCode), int'(prevSeen));
      end else begin
        expT it;
        it = sb.pop_front();
        chk(commCode === it.code, {it.tag, " code"}, int'(commCode), int'(it.code));
        chk(cyc == it.edgeNo, {it.tag, " edge"}, cyc, it.edgeNo);
      end
      prevSeen = commCode;
    end
  end

  task automatic gotoEdge(input int n);
    while (cyc < n - 1) @(negedge clk);
  endtask

  task automatic wrAt(input int n, input logic [2:0] a, input logic [11:0] d);
    gotoEdge(n);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic zcAt(input int n);
    gotoEdge(n);
    zcPulse = 1'b1;
    @(negedge clk);
    zcPulse = 1'b0;
  endtask

  task automatic checkRd(input logic [2:0] a, input int exp, input string tag);
    rdEn = 1'b1; addr = a;
    #1;
    chk(int'(rdData) == exp, tag, int'(rdData), exp);
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, w, a, b, s, s2, m, c, r;
    repeat (3) @(negedge clk);
    chk(commCode == 3'b101, "R1 park during reset", int'(commCode), 5);
    porOk = 1'b1;
    @(negedge clk);
    chk(commCode == 3'b101, "R1 park after reset", int'(commCode), 5);
    checkRd(3'd1, 5, "R2 read control address");

    base = cyc;
    wrAt(base + 2, 3'd6, 12'd40);
    w = base + 4;
    pushExp(3'b001, w, "R1 wake");
    wrAt(w, 3'd1, 12'h040);
    // stopped: crossings and writes elsewhere change nothing
    zcAt(w + 5);
    zcAt(w + 20);
    wrAt(w + 25, 3'd3, 12'hFFF);
    wrAt(w + 27, 3'd0, 12'hFFF);
    gotoEdge(w + 80);
    checkRd(3'd6, 0, "R2 read other address");
    checkRd(3'd1, 1, "R3 stopped hold");

    // automatic mode, f=1, L=40
    a = w + 90;
    pushExp(3'b011, a + 16,  "R6 half of 10");
    pushExp(3'b010, a + 41,  "R6 half of 20");
    pushExp(3'b110, a + 61,  "R6 second 20");
    pushExp(3'b100, a + 78,  "R7 restart");
    pushExp(3'b000, a + 115, "R8 forced step");
    pushExp(3'b010, a + 120, "R10 brake shift");
    pushExp(3'b110, a + 155, "R5 wrap under brake");
    pushExp(3'b001, a + 160, "R10 brake release");
    wrAt(a, 3'd1, 12'h048);
    zcAt(a + 10);
    zcAt(a + 30);
    zcAt(a + 50);
    zcAt(a + 70);
    zcAt(a + 75);
    wrAt(a + 120, 3'd1, 12'h848);
    wrAt(a + 160, 3'd1, 12'h048);
    wrAt(a + 170, 3'd1, 12'h040);
    gotoEdge(a + 220);
    checkRd(3'd1, 1, "R3 after stop");

    // divider: f=2, L=10 -> period 19
    b = a + 230;
    wrAt(b, 3'd6, 12'h80A);
    s = b + 5;
    pushExp(3'b011, s + 19, "R9 factor 2");
    pushExp(3'b010, s + 38, "R9 factor 2 repeat");
    wrAt(s, 3'd1, 12'h048);
    wrAt(s + 45, 3'd1, 12'h040);

    // divider: f=8, L=3 -> period 17
    s2 = s + 60;
    wrAt(s2 - 3, 3'd6, 12'h803);
    pushExp(3'b110, s2 + 17, "R9 factor 8");
    wrAt(s2, 3'd1, 12'h068);
    wrAt(s2 + 20, 3'd1, 12'h040);
    gotoEdge(s2 + 50);

    // manual
    m = s2 + 60;
    pushExp(3'b011, m, "R4 manual state");
    wrAt(m, 3'd1, 12'h05B);
    zcAt(m + 5);
    pushExp(3'b001, m + 10, "R4 manual follow");
    wrAt(m + 10, 3'd1, 12'h059);
    gotoEdge(m + 60);
    checkRd(3'd1, 1, "R4 manual no advance");
    pushExp(3'b110, m + 70, "R4 manual without run");
    wrAt(m + 70, 3'd1, 12'h053);

    // sleep
    pushExp(3'b101, m + 80, "R11 park");
    wrAt(m + 80, 3'd1, 12'h008);
    zcAt(m + 85);
    gotoEdge(m + 130);
    checkRd(3'd1, 5, "R11 parked read");
    c = m + 140;
    pushExp(3'b110, c, "R11 wake restores index");
    pushExp(3'b100, c + 5, "R8 forced f=2 L=3");
    wrAt(c, 3'd1, 12'h048);
    wrAt(c + 7, 3'd1, 12'h040);
    gotoEdge(c + 30);
    checkRd(3'd1, 4, "R5 index 4 code");

    // power-on reset again
    @(posedge clk);
    #1;
    pushExp(3'b101, cyc, "R1 async park");
    porOk = 1'b0;
    repeat (3) @(negedge clk);
    porOk = 1'b1;
    @(negedge clk);
    chk(commCode == 3'b101, "R1 sleep after reset", int'(commCode), 5);
    r = cyc + 3;
    pushExp(3'b001, r, "R5 index reset to 0");
    wrAt(r, 3'd1, 12'h048);
    wrAt(r + 5, 3'd1, 12'h040);
    gotoEdge(r + 10);
    @(negedge clk);
    chk(sb.size() == 0, "R6 all expected steps seen", sb.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule